// File: doc/BRIEF.md
# Masked Level Interrupt Aggregator

This block gathers up to eight device interrupt requests into one pending register. It drives a single level-sensitive request line toward an upstream interrupt controller. Devices raise and drop requests through two vector inputs: one sets bits and one clears them. Software works through a byte-wide register port. It can program an enable mask, read the raw pending bits, and acknowledge one line by writing that line's number. The request line is high whenever at least one pending bit is also enabled. It follows every change to the pending bits or the mask at the next clock edge.

The mask is held in inverted form. A byte written to the mask location is complemented before it is stored as the enable mask, and a read complements it again, so software sees a set bit as a masked line. A second mask/status pair sits at its own two locations. It is a stub: its mask is stored and can be read back, but it never takes part in the request line, and its status always reads zero.

The request line comes from a two-state machine. State `LVL_QUIET` has the line low, and state `LVL_RAISED` has it high. The transition RAISE moves `LVL_QUIET` to `LVL_RAISED` when the next-cycle value of (pending AND enable) is nonzero. The transition DROP moves `LVL_RAISED` to `LVL_QUIET` when that value is zero. Otherwise each state holds.

Top module: `irq_aggregator`

Register select encoding (`reg_sel`): 0 = primary mask, 1 = primary status (read) / acknowledge (write), 2 = secondary mask, 3 = secondary status (read) / secondary acknowledge (write).

## Requirements
- R1: After reset the pending register and the enable mask are zero, `irq_out` is low and `rdata` is zero. A byte read of select 0 then returns 0xFF.
- R2: A write to select 0 stores the complement of `wdata` as the enable mask. A later byte read of select 0 returns the complement of the stored mask, that is, the byte last written.
- R3: `irq_out` is high exactly when (pending AND enable) is nonzero. It reflects each mask write, acknowledge, set or clear from the first clock edge that applies the change.
- R4: A write to select 1 clears the pending bit whose number is `wdata[3:0]`. Numbers 8 to 15 clear nothing, and every other pending bit is kept.
- R5: Each bit set in `set_vec` sets that pending bit, and each bit set in `clr_vec` clears it, at the clock edge where the vector is presented.
- R6: When a bit is both set by `set_vec` and cleared in the same cycle, by `clr_vec` or by an acknowledge, the set wins and the bit ends up pending.
- R7: A byte read of select 1 returns the raw pending register in `rdata[7:0]` with the upper bits zero. A wide read (`rd_wide`=1) of select 1 returns the same zero-extended value. A wide read of any other select returns zero.
- R8: A write to select 2 stores the complement of `wdata` as the secondary mask, and a byte read of select 2 returns the byte written. The secondary mask never changes `irq_out`. A byte read of select 3 returns zero, and a write to select 3 leaves the pending register unchanged.
- R9: `rdata` is registered. It changes at the clock edge after a cycle with `rd_en` high, carries the register values from before that edge's writes, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_wide | input | 1 | Read is 64 bits wide instead of one byte |
| wdata | input | 8 | Write data |
| rdata | output | 64 | Registered read data |
| set_vec | input | 8 | Device request set vector |
| clr_vec | input | 8 | Device request clear vector |
| irq_out | output | 1 | Level request to the upstream controller |

## Verification
A corrupted enable mask shows at the next mask read-back as a wrong complemented byte. It also shows on `irq_out` in the cycle after a pending bit enters the affected position. A lost or stuck pending bit shows on the next status read, and on `irq_out` from the edge where the expected level no longer matches. A stuck request state machine shows one cycle after the last enabled request is acknowledged or masked. Because of this, the bench checks the line after every single stimulus cycle, and it sweeps all 256 mask values and all 16 acknowledge numbers.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_SMASK = 2'd2,
        SEL_SSTAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        LVL_QUIET  = 1'b0,
        LVL_RAISED = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DW     = 8,
    parameter int ACK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DW-1:0]     wdata,
    input  logic [NLINES-1:0] set_vec,
    input  logic [NLINES-1:0] clr_vec,
    output logic [NLINES-1:0] pend_q,
    output logic [NLINES-1:0] en_q,
    output logic [NLINES-1:0] sec_q,
    output logic [NLINES-1:0] pend_nx,
    output logic [NLINES-1:0] en_nx
);

    reg_sel_e          sel;
    logic              ack_wr;
    logic              mask_wr;
    logic              smask_wr;
    logic [NLINES-1:0] ack_clr;
    logic [NLINES-1:0] wbyte_inv;

    assign sel       = reg_sel_e'(reg_sel);
    assign ack_wr    = wr_en && (sel == SEL_STAT);
    assign mask_wr   = wr_en && (sel == SEL_MASK);
    assign smask_wr  = wr_en && (sel == SEL_SMASK);
    assign wbyte_inv = ~wdata[NLINES-1:0];

    // One decoder per line for the acknowledge number
    for (genvar i = 0; i < NLINES; i++) begin : g_ack
        assign ack_clr[i] = ack_wr && (wdata[ACK_W-1:0] == ACK_W'(i));
    end

    // Clears first, then sets, so a same-cycle request survives
    always_comb begin
        pend_nx = (pend_q & ~clr_vec & ~ack_clr) | set_vec;
        en_nx   = mask_wr ? wbyte_inv : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            sec_q  <= '0;
        end else begin
            pend_q <= pend_nx;
            en_q   <= en_nx;
            if (smask_wr) begin
                sec_q <= wbyte_inv;
            end
        end
    end

    assert_mask_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd0) |=> (en_q == ~$past(wdata[NLINES-1:0])));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0 && set_vec == '0) |=> ((pend_q & $past(clr_vec)) == '0));

    assert_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd1 && int'(wdata[ACK_W-1:0]) < NLINES && set_vec == '0)
        |=> (((pend_q >> $past(wdata[ACK_W-1:0])) & NLINES'(1)) == '0));

    assert_sec_ack_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd3 && set_vec == '0 && clr_vec == '0)
        |=> (pend_q == $past(pend_q)));

endmodule

// File: rtl/irq_agg_level.sv
module irq_agg_level
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_nx,
    output logic irq_out
);

    lvl_state_e state_q;
    lvl_state_e state_nx;

    // Next-state: RAISE and DROP transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LVL_QUIET: begin
                if (any_nx) state_nx = LVL_RAISED;
            end
            LVL_RAISED: begin
                if (!any_nx) state_nx = LVL_QUIET;
            end
            default: state_nx = LVL_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_QUIET;
        else        state_q <= state_nx;
    end

    always_comb begin
        irq_out = (state_q == LVL_RAISED);
    end

    assert_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_nx |=> irq_out);

    assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !any_nx |=> !irq_out);

endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
    import irq_agg_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int RW     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_wide,
    input  logic [1:0]        reg_sel,
    input  logic [NLINES-1:0] pend_q,
    input  logic [NLINES-1:0] en_q,
    input  logic [NLINES-1:0] sec_q,
    output logic [RW-1:0]     rdata
);

    reg_sel_e          sel;
    logic [NLINES-1:0] en_inv;
    logic [NLINES-1:0] sec_inv;
    logic [RW-1:0]     rd_nx;

    assign sel     = reg_sel_e'(reg_sel);
    assign en_inv  = ~en_q;
    assign sec_inv = ~sec_q;

    always_comb begin
        rd_nx = '0;
        if (rd_wide) begin
            if (sel == SEL_STAT) rd_nx = RW'(pend_q);
        end else begin
            unique case (sel)
                SEL_MASK:  rd_nx = RW'(en_inv);
                SEL_STAT:  rd_nx = RW'(pend_q);
                SEL_SMASK: rd_nx = RW'(sec_inv);
                SEL_SSTAT: rd_nx = '0;
                default:   rd_nx = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_nx;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    assert_sstat_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_wide && reg_sel == 2'd3) |=> (rdata == '0));

    assert_wide_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_wide && reg_sel != 2'd1) |=> (rdata == '0));

    assert_stat_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == 2'd1) |=> (rdata == RW'($past(pend_q))));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int DW     = 8,
    parameter int ACK_W  = 4,
    parameter int RW     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rd_wide,
    input  logic [DW-1:0]     wdata,
    output logic [RW-1:0]     rdata,
    input  logic [NLINES-1:0] set_vec,
    input  logic [NLINES-1:0] clr_vec,
    output logic              irq_out
);

    logic [NLINES-1:0] pend_q;
    logic [NLINES-1:0] en_q;
    logic [NLINES-1:0] sec_q;
    logic [NLINES-1:0] pend_nx;
    logic [NLINES-1:0] en_nx;
    logic              any_nx;

    irq_agg_regs #(.NLINES(NLINES), .DW(DW), .ACK_W(ACK_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend_q  (pend_q),
        .en_q    (en_q),
        .sec_q   (sec_q),
        .pend_nx (pend_nx),
        .en_nx   (en_nx)
    );

    assign any_nx = |(pend_nx & en_nx);

    irq_agg_level u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_nx  (any_nx),
        .irq_out (irq_out)
    );

    irq_agg_rdmux #(.NLINES(NLINES), .RW(RW)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_wide (rd_wide),
        .reg_sel (reg_sel),
        .pend_q  (pend_q),
        .en_q    (en_q),
        .sec_q   (sec_q),
        .rdata   (rdata)
    );

    assert_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |(pend_q & en_q));

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        rd_wide = 1'b0;
    logic [7:0]  wdata = '0;
    logic [63:0] rdata;
    logic [7:0]  set_vec = '0;
    logic [7:0]  clr_vec = '0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  m_pend = '0;
    logic [7:0]  m_en   = '0;
    logic [7:0]  m_sec  = '0;
    logic [63:0] m_rd   = '0;

    always #4 clk = ~clk;

    irq_aggregator u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rd_wide (rd_wide),
        .wdata   (wdata),
        .rdata   (rdata),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .irq_out (irq_out)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One stimulus cycle; model updated from the requirements, outputs checked after the edge
    task automatic step(input logic wr, input logic rd, input logic wide, input logic [1:0] sel,
                        input logic [7:0] wd, input logic [7:0] sv, input logic [7:0] cv,
                        input string rtag);
        logic [7:0] ack_m;
        wr_en = wr; rd_en = rd; rd_wide = wide; reg_sel = sel;
        wdata = wd; set_vec = sv; clr_vec = cv;
        if (rd) begin
            if (wide) m_rd = (sel == 2'd1) ? {56'd0, m_pend} : 64'd0;
            else case (sel)
                2'd0: m_rd = {56'd0, ~m_en};
                2'd1: m_rd = {56'd0, m_pend};
                2'd2: m_rd = {56'd0, ~m_sec};
                default: m_rd = 64'd0;
            endcase
        end
        ack_m = (wr && sel == 2'd1 && wd[3:0] < 4'd8) ? (8'd1 << wd[2:0]) : 8'd0;
        m_pend = (m_pend & ~cv & ~ack_m) | sv;
        if (wr && sel == 2'd0) m_en  = ~wd;
        if (wr && sel == 2'd2) m_sec = ~wd;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; rd_wide = 1'b0; wdata = '0; set_vec = '0; clr_vec = '0;
        chk(irq_out == |(m_pend & m_en), "R3 irq level", {63'd0, irq_out}, {63'd0, |(m_pend & m_en)});
        chk(rdata == m_rd, rtag, rdata, m_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(irq_out == 1'b0, "R1 irq in reset", {63'd0, irq_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata == 64'd0, "R1 rdata after reset", rdata, 64'd0);
        chk(irq_out == 1'b0, "R1 irq after reset", {63'd0, irq_out}, 64'd0);
        step(0, 1, 0, 2'd0, 0, 0, 0, "R1 mask read after reset");
        step(0, 1, 0, 2'd1, 0, 0, 0, "R1 status read after reset");

        // R2/R3: sweep every enable mask against a fixed pending pattern
        step(0, 0, 0, 2'd0, 0, 8'h24, 0, "R5 set hold");
        for (int m = 0; m < 256; m++) begin
            step(1, 0, 0, 2'd0, ~8'(m), 0, 0, "R3 mask write hold");
            step(0, 1, 0, 2'd0, 0, 0, 0, "R2 mask read-back");
        end

        // R5: sweep pending patterns via set/clear with everything enabled
        step(1, 0, 0, 2'd0, 8'h00, 0, 8'hFF, "R5 clear all");
        for (int p = 0; p < 256; p += 7) begin
            step(0, 0, 0, 2'd0, 0, 8'(p), 0, "R5 set hold");
            step(0, 1, 0, 2'd1, 0, 0, 0, "R5 status after set");
            step(0, 0, 0, 2'd0, 0, 0, 8'(p * 3), "R5 clear hold");
            step(0, 1, 1, 2'd1, 0, 0, 0, "R7 wide status after clear");
        end

        // R4: every acknowledge number against a full pending register
        for (int k = 0; k < 16; k++) begin
            step(0, 0, 0, 2'd0, 0, 8'hFF, 0, "R5 refill");
            step(1, 0, 0, 2'd1, 8'(k), 0, 0, "R4 ack hold");
            step(0, 1, 0, 2'd1, 0, 0, 0, "R4 status after ack");
        end
        // R4: acknowledging the last enabled line drops the output
        step(0, 0, 0, 2'd0, 0, 0, 8'hFF, "R5 clear all");
        step(1, 0, 0, 2'd0, 8'hF7, 8'h08, 0, "R3 enable line 3");
        step(1, 0, 0, 2'd1, 8'd3, 0, 0, "R4 ack last line");

        // R6: set beats acknowledge and clear in the same cycle
        step(0, 0, 0, 2'd0, 0, 8'h08, 0, "R5 set bit 3");
        step(1, 0, 0, 2'd1, 8'd3, 8'h08, 0, "R6 ack and set");
        step(0, 1, 0, 2'd1, 0, 0, 0, "R6 status after ack and set");
        step(0, 0, 0, 2'd0, 0, 8'h81, 8'h81, "R6 clear and set");
        step(0, 1, 0, 2'd1, 0, 0, 0, "R6 status after clear and set");

        // R7: wide reads of the other selects return zero
        step(0, 1, 1, 2'd0, 0, 0, 0, "R7 wide mask read");
        step(0, 1, 1, 2'd2, 0, 0, 0, "R7 wide secondary mask read");
        step(0, 1, 1, 2'd3, 0, 0, 0, "R7 wide secondary status read");

        // R8: secondary controller stubs
        step(1, 0, 0, 2'd0, 8'hFF, 0, 8'hFF, "R8 primary mask all");
        step(0, 0, 0, 2'd0, 0, 8'h0F, 0, "R8 pending with no enable");
        step(1, 0, 0, 2'd2, 8'h00, 0, 0, "R8 secondary mask write");
        step(0, 1, 0, 2'd2, 0, 0, 0, "R8 secondary mask read-back");
        step(0, 1, 0, 2'd3, 0, 0, 0, "R8 secondary status zero");
        step(1, 0, 0, 2'd3, 8'd1, 0, 0, "R8 secondary ack");
        step(0, 1, 0, 2'd1, 0, 0, 0, "R8 status after secondary ack");
        step(1, 0, 0, 2'd2, 8'h5A, 0, 0, "R8 secondary mask write 2");
        step(0, 1, 0, 2'd2, 0, 0, 0, "R8 secondary mask read-back 2");

        // R9: read returns pre-write value, then holds
        step(1, 1, 0, 2'd0, 8'h00, 0, 0, "R9 read during mask write");
        step(0, 0, 0, 2'd0, 0, 8'hF0, 0, "R9 hold after set");
        step(1, 0, 0, 2'd1, 8'd0, 0, 0, "R9 hold after ack");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule